// File: doc/BRIEF.md
# DDR Write Lane Strobe and Data Generator

This block turns one write burst from a memory controller into the pin-level activity of a double-data-rate write lane: a group of DQ data bits, one DQS strobe and one data-mask bit, each with its own output enable. The lane runs from a single fast clock at four times the strobe rate. Each strobe period is therefore four fast-clock phases and carries two data beats. Data changes on phases 0 and 2 and the strobe changes on phases 1 and 3, which places every strobe edge a quarter period after the data edge, in the middle of the data eye.

A burst is offered with `req_valid` together with all eight data words and their eight mask bits. It is taken when `req_ready` is high. The lane first drives the strobe low for one strobe period (preamble). It then sends the eight beats, with the strobe toggling in the centre of each beat, and holds the strobe low for one more period (postamble). After that it releases every pin to tristate. All outputs come straight from flops. A parameter selects eight or four DQ bits per strobe. A second parameter marks a low-power memory mode, in which the four-bit width is rejected when the design is elaborated.

Top module: `ddr_wr_lane`

## Requirements
- R1: `req_ready` is 1 exactly when the lane is idle. A burst is taken at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` reads 0 from that edge on. The first preamble cycle shows on the outputs after the next edge.
- R2: While idle, `dq_oe`, `dqs_oe` and `dm_oe` are 0, and `dq_o`, `dqs_o` and `dm_o` are 0. This includes the state right after reset.
- R3: The preamble lasts 4 output cycles. In these cycles `dqs_oe` is 1 and `dqs_o` is 0, while `dq_oe` and `dm_oe` are 0.
- R4: The data window follows the preamble and lasts 16 output cycles with `dq_oe` 1. Beat b (b = 0..7) occupies window cycles 2b and 2b+1. During beat b, `dq_o` equals `req_data[b*DQ_W +: DQ_W]` as captured at acceptance, so beat 0 is the least significant word.
- R5: Within each 4-cycle strobe period of the data window, `dqs_o` is 0, 1, 1, 0 on phases 0 to 3. The strobe therefore rises one cycle after the first beat of the period starts and falls one cycle after the second beat starts.
- R6: `dm_oe` equals `dq_oe`. During beat b, `dm_o` equals `req_mask[b]`, where 1 means the byte of that beat is not written.
- R7: The postamble lasts 4 output cycles after the data window. In these cycles `dqs_oe` is 1 and `dqs_o` is 0, while `dq_oe` and `dm_oe` are 0. After that, all enables return to 0.
- R8: A request offered while the lane is busy is ignored. Changing `req_data` or `req_mask` during a burst does not change the beats being sent.
- R9: `req_ready` returns to 1 during the last postamble output cycle. A request taken at the next edge produces a preamble directly after the one idle output cycle that follows the postamble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, four times the strobe rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A burst is offered |
| req_ready | output | 1 | Lane idle, burst can be taken |
| req_data | input | BURST_LEN*DQ_W | All beats of the burst, beat 0 in the low bits |
| req_mask | input | BURST_LEN | Per-beat mask, bit b for beat b |
| dq_o | output | DQ_W | Data lane value |
| dq_oe | output | 1 | Data lane output enable |
| dqs_o | output | 1 | Strobe value |
| dqs_oe | output | 1 | Strobe output enable |
| dm_o | output | 1 | Data-mask value |
| dm_oe | output | 1 | Data-mask output enable |

## Verification
The bench builds the lane with eight DQ bits, a burst of eight beats and the low-power mode off. With these values one burst is only 26 cycles, so the bench can run all 256 mask patterns back to back, each with its own computed data words. Every output cycle of every burst is compared with a value derived from the slot number. On alternate bursts the bench drives a conflicting request with inverted payload while the lane is busy, so the capture-once rule and the reopening of `req_ready` are exercised across the whole sweep.

// File: rtl/dwl_pkg.sv
package dwl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2,
    ST_POST = 2'd3
  } lane_st_e;

  localparam int PHASES = 4;
  localparam int PH_W   = 2;
endpackage

// File: rtl/dwl_sequencer.sv
module dwl_sequencer
  import dwl_pkg::*;
#(
  parameter int BURST_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  output logic                 accept,
  output lane_st_e             state,
  output logic [PH_W-1:0]      phase,
  output logic [$clog2(BURST_LEN)-1:0] beat_idx
);
  localparam int PERIODS = BURST_LEN / 2;
  localparam int PER_W   = (PERIODS > 1) ? $clog2(PERIODS) : 1;
  localparam int BW      = $clog2(BURST_LEN);
  localparam logic [PER_W-1:0] LAST_PER = PER_W'(PERIODS - 1);
  localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(PHASES - 1);

  logic [PER_W-1:0] period;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign beat_idx  = BW'({period, phase[1]});

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      phase  <= '0;
      period <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          phase  <= '0;
          period <= '0;
          if (accept) state <= ST_PRE;
        end
        ST_PRE: begin
          phase <= phase + 1'b1;
          if (phase == LAST_PH) begin
            state  <= ST_DATA;
            period <= '0;
          end
        end
        ST_DATA: begin
          phase <= phase + 1'b1;
          if (phase == LAST_PH) begin
            if (period == LAST_PER) state <= ST_POST;
            else period <= period + 1'b1;
          end
        end
        default: begin
          phase <= phase + 1'b1;
          if (phase == LAST_PH) state <= ST_IDLE;
        end
      endcase
    end
  end

  AST_ACCEPT_STARTS_PRE: assert property (@(posedge clk) disable iff (rst)
    accept |=> (state == ST_PRE && phase == '0)); // R1

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA) |=> (state != ST_IDLE)); // R8
endmodule

// File: rtl/dwl_beat_store.sv
module dwl_beat_store #(
  parameter int BURST_LEN = 8,
  parameter int DQ_W      = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load,
  input  logic [BURST_LEN*DQ_W-1:0]     load_data,
  input  logic [BURST_LEN-1:0]          load_mask,
  input  logic [$clog2(BURST_LEN)-1:0]  rd_idx,
  output logic [DQ_W-1:0]               rd_data,
  output logic                          rd_mask
);
  logic [DQ_W-1:0]      beat_mem [BURST_LEN];
  logic [BURST_LEN-1:0] mask_q;

  for (genvar b = 0; b < BURST_LEN; b++) begin : g_beat
    always_ff @(posedge clk) begin
      if (load) beat_mem[b] <= load_data[b*DQ_W +: DQ_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       mask_q <= '0;
    else if (load) mask_q <= load_mask;
  end

  assign rd_data = beat_mem[rd_idx];
  assign rd_mask = mask_q[rd_idx];
endmodule

// File: rtl/dwl_out_stage.sv
module dwl_out_stage
  import dwl_pkg::*;
#(
  parameter int DQ_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  lane_st_e         state,
  input  logic [PH_W-1:0]  phase,
  input  logic [DQ_W-1:0]  beat_data,
  input  logic             beat_mask,
  output logic [DQ_W-1:0]  dq_o,
  output logic             dq_oe,
  output logic             dqs_o,
  output logic             dqs_oe,
  output logic             dm_o,
  output logic             dm_oe
);
  logic in_window, in_burst, strobe_hi;

  assign in_burst  = (state != ST_IDLE);
  assign in_window = (state == ST_DATA);
  assign strobe_hi = in_window && (phase[0] ^ phase[1]);

  for (genvar i = 0; i < DQ_W; i++) begin : g_dq
    always_ff @(posedge clk) begin
      if (rst) dq_o[i] <= 1'b0;
      else     dq_o[i] <= in_window & beat_data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe  <= 1'b0;
      dqs_o  <= 1'b0;
      dqs_oe <= 1'b0;
      dm_o   <= 1'b0;
      dm_oe  <= 1'b0;
    end else begin
      dq_oe  <= in_window;
      dm_oe  <= in_window;
      dm_o   <= in_window & beat_mask;
      dqs_oe <= in_burst;
      dqs_o  <= strobe_hi;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !dqs_oe |-> (!dq_oe && !dm_oe && !dqs_o && !dm_o)); // R2

  AST_PRE_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(dqs_oe) |-> (!dqs_o && !dq_oe)); // R3

  AST_EDGE_CENTRED: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && $past(dq_oe) && !$stable(dq_o)) |-> $stable(dqs_o)); // R5

  AST_DM_TRACKS_DQ: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> dm_oe); // R6

  AST_POST_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(dqs_oe) |-> ($past(!dqs_o) && $past(!dq_oe))); // R7
endmodule

// File: rtl/ddr_wr_lane.sv
module ddr_wr_lane
  import dwl_pkg::*;
#(
  parameter int DQ_W       = 8,
  parameter int BURST_LEN  = 8,
  parameter bit LOW_POWER  = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [BURST_LEN*DQ_W-1:0] req_data,
  input  logic [BURST_LEN-1:0]      req_mask,
  output logic [DQ_W-1:0]           dq_o,
  output logic                      dq_oe,
  output logic                      dqs_o,
  output logic                      dqs_oe,
  output logic                      dm_o,
  output logic                      dm_oe
);
  localparam int BW = $clog2(BURST_LEN);

  initial begin
    assert ((DQ_W == 8) || (DQ_W == 4 && !LOW_POWER))
      else $error("DQ_W must be 8, or 4 outside low-power mode");
  end

  logic            accept;
  lane_st_e        state;
  logic [PH_W-1:0] phase;
  logic [BW-1:0]   beat_idx;
  logic [DQ_W-1:0] beat_data;
  logic            beat_mask;

  dwl_sequencer #(.BURST_LEN(BURST_LEN)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .state     (state),
    .phase     (phase),
    .beat_idx  (beat_idx)
  );

  dwl_beat_store #(.BURST_LEN(BURST_LEN), .DQ_W(DQ_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_data (req_data),
    .load_mask (req_mask),
    .rd_idx    (beat_idx),
    .rd_data   (beat_data),
    .rd_mask   (beat_mask)
  );

  dwl_out_stage #(.DQ_W(DQ_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .phase     (phase),
    .beat_data (beat_data),
    .beat_mask (beat_mask),
    .dq_o      (dq_o),
    .dq_oe     (dq_oe),
    .dqs_o     (dqs_o),
    .dqs_oe    (dqs_oe),
    .dm_o      (dm_o),
    .dm_oe     (dm_oe)
  );

  AST_READY_LOW_IN_BURST: assert property (@(posedge clk) disable iff (rst)
    (dq_oe || (dqs_oe && !$past(dqs_oe))) |-> !req_ready); // R1
endmodule

// File: tb/ddr_wr_lane_bench.sv
module ddr_wr_lane_bench;
  localparam int W  = 8;
  localparam int BL = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [BL*W-1:0] req_data = '0;
  logic [BL-1:0]   req_mask = '0;
  logic [W-1:0] dq_o;
  logic dq_oe, dqs_o, dqs_oe, dm_o, dm_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ddr_wr_lane #(.DQ_W(W), .BURST_LEN(BL), .LOW_POWER(1'b0)) u_ddr_wr_lane (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .req_mask(req_mask), .dq_o(dq_o), .dq_oe(dq_oe),
    .dqs_o(dqs_o), .dqs_oe(dqs_oe), .dm_o(dm_o), .dm_oe(dm_oe)
  );

  // packed view {dq_oe, dqs_oe, dm_oe, dqs_o, dm_o, dq_o}
  function automatic logic [W+4:0] pins();
    return {dq_oe, dqs_oe, dm_oe, dqs_o, dm_o, dq_o};
  endfunction

  task automatic check(input string tag, input logic [W+4:0] act, input logic [W+4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_rdy(input string tag, input logic exp);
    checks++;
    if (req_ready !== exp) begin
      errors++;
      $display("FAIL %s: ready actual %b expected %b", tag, req_ready, exp);
    end
  endtask

  function automatic logic [W-1:0] word(input int n, input int b);
    return W'((n * 37 + b * 11 + 5) & 8'hFF);
  endfunction

  task automatic run_burst(input int n, input bit junk);
    logic [BL*W-1:0] d;
    logic [BL-1:0]   m;
    for (int b = 0; b < BL; b++) d[b*W +: W] = word(n, b);
    m = BL'(n);
    check_rdy("R1 ready before request", 1'b1);
    req_data  = d;
    req_mask  = m;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = junk;
    req_data  = ~d;
    req_mask  = ~m;
    check_rdy("R1 ready drops on accept", 1'b0);
    for (int s = 0; s < 24; s++) begin
      @(posedge clk);
      @(negedge clk);
      if (s >= 20) req_valid = 1'b0;
      if (s < 4) begin
        check("R3 preamble", pins(), {3'b010, 2'b00, {W{1'b0}}});
      end else if (s < 20) begin
        int k  = s - 4;
        int ph = k % 4;
        int bt = (k / 4) * 2 + (ph >= 2 ? 1 : 0);
        logic st = (ph == 1 || ph == 2);
        check(junk ? "R8 busy request ignored" : "R4 R5 R6 data window",
              pins(), {3'b111, st, m[bt], d[bt*W +: W]});
      end else begin
        check("R7 postamble", pins(), {3'b010, 2'b00, {W{1'b0}}});
      end
      check_rdy(s == 23 ? "R9 ready reopens" : "R1 ready low in burst", s == 23);
    end
    @(posedge clk);
    @(negedge clk);
    check("R7 R2 released to idle", pins(), '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R2 reset state", pins(), '0);
    check_rdy("R2 reset ready", 1'b1);
    for (int n = 0; n < 256; n++) run_burst(n, n[0]);
    repeat (4) begin
      @(posedge clk);
      @(negedge clk);
      check("R2 idle quiet", pins(), '0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule